// File: doc/BRIEF.md
# Selectable ADC Sign-Format Converter

This block sits directly behind a high-speed 8-bit ADC in the fast sample clock domain. It turns every raw sample into a signed two's-complement value. The ADC can be strapped to emit either offset-binary or two's-complement codes, and the firmware cannot read that strap back. The host therefore sets the sign convention at run time through a 2-bit format code. It does so with a command write in the slower control clock domain.

A command decoder in the control domain keeps the format code in a register. Only one opcode, 0x33, writes that register. The code crosses into the sample domain through a two-flop synchronizer chain. There it selects how each accepted sample is converted in a single registered stage.

Samples enter and leave on valid/ready streams. A sample is accepted on a clock edge when `s_valid` and `s_ready` are both high. An output word is consumed on an edge when `m_valid` and `m_ready` are both high. While the output holds a word that has not been consumed, the word stays fixed and the input stalls. When the output is empty, or is being consumed in the same cycle, a new sample can move in, so full throughput is one sample per clock.

Top module: `adc_fmt_converter`

## Requirements
- R1: After reset the format code is 2'b00 (offset-binary): input 0x80 gives 0, 0x00 gives -128 (0x80), 0xFF gives +127 (0x7F); in general output = input - 128.
- R2: With format code 2'b01 (two's-complement) the sample passes unchanged: 0x00 gives 0, 0x80 gives -128, 0x7F gives +127.
- R3: The reserved format codes 2'b10 and 2'b11 convert exactly like offset-binary (output = input - 128).
- R4: A command with `cmd_valid` high and `cmd_opcode` equal to 0x33 loads `cmd_data[1:0]` as the format code. Any other opcode, including the reserved 0x32, leaves the format unchanged.
- R5: A format written in the control domain reaches the sample domain through a two-flop chain. Each change seen by the conversion equals the control-domain value from two sample-clock edges earlier. Samples accepted 4 or more sample cycles after the write use the new format.
- R6: A sample accepted on an edge appears on `m_data` with `m_valid` high right after that edge, converted with the format in effect in the sample domain on that edge (one-cycle latency).
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged on the next cycle.
- R8: `s_ready` is high exactly when the output stage is empty or is being consumed (`!m_valid || m_ready`).
- R9: During and right after reset `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control-domain clock |
| ctl_rst_n | input | 1 | Control-domain asynchronous reset, active low |
| cmd_valid | input | 1 | Command write strobe |
| cmd_opcode | input | 8 | Command opcode; 0x33 selects the format register |
| cmd_data | input | 2 | Format code carried by the command |
| smp_clk | input | 1 | Sample-domain clock |
| smp_rst_n | input | 1 | Sample-domain asynchronous reset, active low |
| s_valid | input | 1 | Raw sample valid |
| s_ready | output | 1 | Converter can accept a raw sample |
| s_data | input | 8 | Raw ADC sample |
| m_valid | output | 1 | Converted sample valid |
| m_ready | input | 1 | Downstream accepts the converted sample |
| m_data | output | 8 | Converted signed two's-complement sample |

## Verification
The assertions are checked on every cycle and cover four things. They check the stream rules: the one-cycle latency, the output holding while stalled, and input stall under back-pressure. They check that the converted value fits the synchronized format on each accept. They check that non-matching opcodes leave the format register alone. They check that every change at the synchronizer output repeats the control value from two sample edges before.

Some behaviours show only through the bench's scenarios, which feed the block's ports. These are the exact corner mappings for each code, full sweeps of all 256 inputs per format, the reserved-opcode writes having no visible effect, and the new format taking hold within the stated settling time.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  typedef enum logic [1:0] {
    FMT_OFFSET = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_RSV_A  = 2'b10,
    FMT_RSV_B  = 2'b11
  } fmt_e;

  localparam logic [7:0] OPC_FORMAT   = 8'h33;
  localparam logic [7:0] OPC_RESERVED = 8'h32;  // never decoded
endpackage

// File: rtl/fmt_cmd_reg.sv
module fmt_cmd_reg #(
  parameter int OPC_W = 8,
  parameter int FMT_W = 2,
  parameter logic [OPC_W-1:0] MATCH_OPC = 8'h33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [OPC_W-1:0] wr_opcode,
  input  logic [FMT_W-1:0] wr_data,
  output logic [FMT_W-1:0] fmt_q
);
  // Only the matching opcode loads; everything else, including the
  // reserved neighbour opcode, falls through without touching state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fmt_q <= '0;
    else if (wr_valid && (wr_opcode == MATCH_OPC))
      fmt_q <= wr_data;
  end
endmodule

// File: rtl/fmt_sync.sv
module fmt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  // Asynchronous-register chain: keep these flops adjacent, no logic between.
  logic [WIDTH-1:0] meta_chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) meta_chain[g] <= '0;
          else        meta_chain[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) meta_chain[g] <= '0;
          else        meta_chain[g] <= meta_chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = meta_chain[STAGES-1];
endmodule

// File: rtl/sample_conv.sv
module sample_conv
  import adcfmt_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int FMT_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FMT_W-1:0]    fmt,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data
);
  localparam int MSB = SAMPLE_W - 1;

  logic                accept;
  logic [SAMPLE_W-1:0] conv;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // Offset-binary to signed: flipping the MSB equals subtracting half range.
  // Reserved codes take the offset-binary path.
  always_comb begin
    if (fmt == FMT_W'(FMT_TWOS))
      conv = in_data;
    else
      conv = {~in_data[MSB], in_data[MSB-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= conv;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_fmt_converter.sv
module adc_fmt_converter #(
  parameter int SAMPLE_W    = 8,
  parameter int FMT_W       = 2,
  parameter int OPC_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [OPC_W-1:0] FMT_OPCODE = 8'h33
) (
  input  logic                ctl_clk,
  input  logic                ctl_rst_n,
  input  logic                cmd_valid,
  input  logic [OPC_W-1:0]    cmd_opcode,
  input  logic [FMT_W-1:0]    cmd_data,
  input  logic                smp_clk,
  input  logic                smp_rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_data
);
  logic [FMT_W-1:0] fmt_ctl_q;
  logic [FMT_W-1:0] fmt_smp;

  fmt_cmd_reg #(.OPC_W(OPC_W), .FMT_W(FMT_W), .MATCH_OPC(FMT_OPCODE)) u_reg (
    .clk       (ctl_clk),
    .rst_n     (ctl_rst_n),
    .wr_valid  (cmd_valid),
    .wr_opcode (cmd_opcode),
    .wr_data   (cmd_data),
    .fmt_q     (fmt_ctl_q)
  );

  fmt_sync #(.WIDTH(FMT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (smp_clk),
    .rst_n   (smp_rst_n),
    .d_async (fmt_ctl_q),
    .q_sync  (fmt_smp)
  );

  sample_conv #(.SAMPLE_W(SAMPLE_W), .FMT_W(FMT_W)) u_conv (
    .clk       (smp_clk),
    .rst_n     (smp_rst_n),
    .fmt       (fmt_smp),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (s_data),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (m_data)
  );
endmodule

// File: rtl/adc_fmt_checker.sv
module adc_fmt_checker #(
  parameter int SAMPLE_W = 8,
  parameter int FMT_W    = 2,
  parameter int OPC_W    = 8,
  parameter logic [OPC_W-1:0] FMT_OPCODE = 8'h33
) (
  input logic                ctl_clk,
  input logic                ctl_rst_n,
  input logic                cmd_valid,
  input logic [OPC_W-1:0]    cmd_opcode,
  input logic [FMT_W-1:0]    fmt_ctl_q,
  input logic                smp_clk,
  input logic                smp_rst_n,
  input logic [FMT_W-1:0]    fmt_smp,
  input logic                s_valid,
  input logic                s_ready,
  input logic [SAMPLE_W-1:0] s_data,
  input logic                m_valid,
  input logic                m_ready,
  input logic [SAMPLE_W-1:0] m_data
);
  localparam logic [SAMPLE_W-1:0] HALF = {1'b1, {(SAMPLE_W-1){1'b0}}};

  assert_other_opcode_R4: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    (cmd_valid && cmd_opcode != FMT_OPCODE) |=> $stable(fmt_ctl_q));

  assert_sync_delay_R5: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (fmt_smp != $past(fmt_smp)) |-> (fmt_smp == $past(fmt_ctl_q, 2)));

  assert_accept_latency_R6: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (s_valid && s_ready) |=> m_valid);

  assert_twos_pass_R2: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (s_valid && s_ready && fmt_smp == FMT_W'(1)) |=> (m_data == $past(s_data)));

  assert_offset_conv_R1: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (s_valid && s_ready && fmt_smp == FMT_W'(0)) |=> (m_data == ($past(s_data) - HALF)));

  assert_reserved_conv_R3: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (s_valid && s_ready && fmt_smp[1]) |=> (m_data == ($past(s_data) - HALF)));

  assert_hold_R7: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_stall_R8: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  always_comb begin
    if (!smp_rst_n) begin
      assert_reset_idle_R9: assert (!m_valid && s_ready);
    end
  end
endmodule

bind adc_fmt_converter adc_fmt_checker #(
  .SAMPLE_W(SAMPLE_W), .FMT_W(FMT_W), .OPC_W(OPC_W), .FMT_OPCODE(FMT_OPCODE)
) u_chk (
  .ctl_clk    (ctl_clk),
  .ctl_rst_n  (ctl_rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_opcode (cmd_opcode),
  .fmt_ctl_q  (fmt_ctl_q),
  .smp_clk    (smp_clk),
  .smp_rst_n  (smp_rst_n),
  .fmt_smp    (fmt_smp),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .s_data     (s_data),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data)
);

// File: tb/tb_adc_fmt_converter.sv
`timescale 1ns/1ps
module tb_adc_fmt_converter;
  logic       ctl_clk = 0, ctl_rst_n = 0;
  logic       cmd_valid = 0;
  logic [7:0] cmd_opcode = 0;
  logic [1:0] cmd_data = 0;
  logic       smp_clk = 0, smp_rst_n = 0;
  logic       s_valid = 0;
  logic       s_ready;
  logic [7:0] s_data = 0;
  logic       m_valid;
  logic       m_ready = 1;
  logic [7:0] m_data;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;
  bit bp_mode = 0;
  int bp_cnt = 0;

  // reference model state
  bit       exp_v = 0;
  bit [7:0] exp_d = 0;
  int       cur_fmt = 0;   // format the bench believes is in force
  string    tag = "R1";

  always #2 smp_clk = ~smp_clk;   // 250 MHz
  always #5 ctl_clk = ~ctl_clk;   // control clock

  adc_fmt_converter dut (.*);

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] ref_conv(int fmt, bit [7:0] d);
    int v;
    if (fmt == 1) return d;
    v = int'(d) - 128;
    return v[7:0];
  endfunction

  // Model compared and advanced mid-cycle; inputs change only 1 ns after posedge.
  always @(negedge smp_clk) begin
    if (smp_rst_n && !done) begin
      check("R6", m_valid, exp_v);
      if (exp_v) check(tag, m_data, exp_d);
      check("R8", s_ready, !exp_v || m_ready);
      if (s_valid && (!exp_v || m_ready)) begin
        exp_v = 1;
        exp_d = ref_conv(cur_fmt, s_data);
      end else if (m_ready) begin
        exp_v = 0;
      end
    end
  end

  always @(posedge smp_clk) begin
    #1;
    bp_cnt++;
    m_ready = bp_mode ? (((bp_cnt * 7) % 5) > 1) : 1'b1;
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge smp_clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic send(bit [7:0] d);
    bit ok;
    s_valid = 1; s_data = d;
    forever begin
      @(negedge smp_clk); ok = s_ready;
      @(posedge smp_clk); #1;
      if (ok) break;
    end
    s_valid = 0;
  endtask

  task automatic drain();
    repeat (6) @(posedge smp_clk);
    #1;
  endtask

  task automatic write_cmd(bit [7:0] op, bit [1:0] d);
    @(posedge ctl_clk); #1;
    cmd_valid = 1; cmd_opcode = op; cmd_data = d;
    @(posedge ctl_clk); #1;
    cmd_valid = 0;
  endtask

  // R5: 4 sample cycles after the control edge are allowed for settling
  task automatic set_fmt(bit [1:0] f);
    write_cmd(8'h33, f);
    repeat (4) @(posedge smp_clk);
    #1;
    cur_fmt = f;
  endtask

  task automatic sweep();
    for (int i = 0; i < 256; i++) send(8'(i));
    drain();
  endtask

  initial begin
    #1;
    check("R9", m_valid, 0);
    check("R9", s_ready, 1);
    #20;
    ctl_rst_n = 1; smp_rst_n = 1;
    @(negedge smp_clk);
    check("R9", m_valid, 0);
    check("R9", s_ready, 1);
    @(posedge smp_clk); #1;

    // R1: default offset-binary corners
    tag = "R1";
    send(8'h80); send(8'h00); send(8'hFF); drain();
    sweep();

    // R4: reserved opcode 0x32 and another opcode must not change the format
    tag = "R4";
    write_cmd(8'h32, 2'b01);
    write_cmd(8'h11, 2'b01);
    repeat (6) @(posedge smp_clk); #1;
    send(8'h80); send(8'h00); send(8'h7F); drain();

    // R2 + R5: switch to two's-complement
    set_fmt(2'b01);
    tag = "R5";
    send(8'h90);
    tag = "R2";
    send(8'h00); send(8'h80); send(8'h7F); drain();
    sweep();

    // R3: reserved codes fall back to offset-binary
    set_fmt(2'b10);
    tag = "R3";
    send(8'h80); send(8'h00); send(8'hFF); drain();
    sweep();
    set_fmt(2'b11);
    send(8'h80); send(8'h7F); drain();
    sweep();

    // R7: back-pressure with a back-to-back stream
    set_fmt(2'b01);
    tag = "R7";
    bp_mode = 1;
    for (int i = 0; i < 200; i++) send(8'((i * 37) ^ 8'h5A));
    bp_mode = 0;
    drain();
    set_fmt(2'b00);
    bp_mode = 1;
    for (int i = 0; i < 200; i++) send(8'(i * 11));
    bp_mode = 0;
    drain();

    finish_run();
  end
endmodule